// File: doc/BRIEF.md
# Static Dual-Issue Packet Decoder

This block sits between instruction fetch and two fixed issue pipes. Each cycle it may receive one 64-bit packet together with the byte address the packet was fetched from. The packet carries two 32-bit instructions. The lower word feeds an integer pipe that runs ALU operations and branches. The upper word feeds a memory pipe that runs loads and stores. The block splits the packet, classifies each word against the type its slot allows, and extracts the register numbers, the function field and the sign-extended immediate. It also works out the program counter of each slot.

A packet is legal only under four conditions. Each slot must hold its own type, or the canonical no-operation word as filler. The packet address must sit on an 8-byte boundary. The memory instruction must not read a register that the integer instruction in the same packet writes. A legal packet raises both slot valids together. An illegal packet raises the matching error flags and a combined error, and keeps both slot valids low. All outputs are registered, so results appear one cycle after the packet is presented.

Top module: `pair_issue_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it, both slot valids, the four error flags and the combined error are low.
- R2: Outputs follow an input packet by exactly one clock cycle. A cycle with `pkt_valid` low yields low valids and low error flags in the next cycle, whatever the address and data inputs hold.
- R3: Slot 0 is bits 31:0 of `pkt_data`. It accepts opcode bits[6:0] 0x33 (register ALU, class 0), 0x13 (immediate ALU, class 1), 0x63 (branch, class 2), 0x37 (upper-immediate load, class 3) and 0x17 (pc-relative upper immediate, class 4), reporting the class on `s0_class`.
- R4: Slot 1 is bits 63:32 of `pkt_data`. It accepts opcode 0x03 (load, `s1_store`=0) and 0x23 (store, `s1_store`=1).
- R5: The word 0x00000013 is a legal filler in either slot. It sets `s0_nop` or `s1_nop`; in slot 1 it reads and writes no register and reports zero fields.
- R6: Any other slot 0 word sets `err_slot0`, and any other slot 1 word sets `err_slot1`.
- R7: A packet address whose bits 2:0 are not all zero sets `err_align`.
- R8: `err_dep` is set when slot 0 writes a nonzero rd (classes 0, 1, 3, 4; a branch writes nothing) that equals the slot 1 rs1 (load or store), or the slot 1 rs2 (store only).
- R9: Any error flag sets `pkt_err` and forces both valids low. A packet without errors raises `s0_valid` and `s1_valid` together.
- R10: `s0_pc` equals the packet address and `s1_pc` equals the packet address plus 4.
- R11: The immediate is sign-extended to 32 bits from the format of the opcode, as follows. Loads and immediate ALU ops use bits 31:20. Stores use bits 31:25 and 11:7. Branches use bits 31, 7, 30:25 and 11:8 with a zero LSB. Upper-immediate ops use bits 31:12 over 12 zeros. Register ALU ops report zero.
- R12: rd (bits 11:7), rs1 (bits 19:15), rs2 (bits 24:20) and funct3 (bits 14:12) are reported only where the format has them, and are zero otherwise. Slot 0 reports rd for classes 0, 1, 3 and 4, rs1 and funct3 for classes 0, 1 and 2, and rs2 for classes 0 and 2. Slot 1 reports rd for loads, rs1 and funct3 for loads and stores, and rs2 for stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | A packet is presented this cycle |
| pkt_addr | input | ADDR_W | Byte address of the packet |
| pkt_data | input | 64 | Packet, slot 0 in the low word |
| s0_valid | output | 1 | Slot 0 accepted |
| s0_class | output | 3 | Slot 0 operation class |
| s0_nop | output | 1 | Slot 0 is the filler word |
| s0_rd | output | 5 | Slot 0 destination register |
| s0_rs1 | output | 5 | Slot 0 first source |
| s0_rs2 | output | 5 | Slot 0 second source |
| s0_funct3 | output | 3 | Slot 0 function field |
| s0_imm | output | 32 | Slot 0 immediate |
| s0_pc | output | ADDR_W | Slot 0 program counter |
| s1_valid | output | 1 | Slot 1 accepted |
| s1_store | output | 1 | Slot 1 is a store |
| s1_nop | output | 1 | Slot 1 is the filler word |
| s1_rd | output | 5 | Slot 1 destination register |
| s1_rs1 | output | 5 | Slot 1 base register |
| s1_rs2 | output | 5 | Slot 1 store data register |
| s1_funct3 | output | 3 | Slot 1 width field |
| s1_imm | output | 32 | Slot 1 offset |
| s1_pc | output | ADDR_W | Slot 1 program counter |
| err_align | output | 1 | Packet address misaligned |
| err_slot0 | output | 1 | Wrong type in slot 0 |
| err_slot1 | output | 1 | Wrong type in slot 1 |
| err_dep | output | 1 | Dependency inside the packet |
| pkt_err | output | 1 | Packet rejected |

## Verification
Alignment, slot typing and the operand dependency compare are separate paths that all resolve in the same cycle. A single packet can therefore trip several of them at once. The bench presents packets that are both misaligned and dependent, and packets with wrong types in both slots. It expects every matching flag in the same output cycle, the combined error high and both valids low. It also sends near misses, which must leave `err_dep` clear: a branch whose immediate bits sit where rd would be, and a load whose immediate bits sit where rs2 would be.

// File: rtl/pid_pkg.sv
package pid_pkg;

    localparam int INSN_W     = 32;
    localparam int INSN_BYTES = INSN_W / 8;
    localparam int REG_W      = 5;
    localparam int SLOTS      = 2;
    localparam int PKT_W      = SLOTS * INSN_W;
    localparam int PKT_BYTES  = PKT_W / 8;

    localparam logic [6:0] OPC_OP     = 7'h33;
    localparam logic [6:0] OPC_OPIMM  = 7'h13;
    localparam logic [6:0] OPC_BRANCH = 7'h63;
    localparam logic [6:0] OPC_LUI    = 7'h37;
    localparam logic [6:0] OPC_AUIPC  = 7'h17;
    localparam logic [6:0] OPC_LOAD   = 7'h03;
    localparam logic [6:0] OPC_STORE  = 7'h23;

    localparam logic [INSN_W-1:0] FILLER_WORD = 32'h0000_0013;

    typedef logic [INSN_W-1:0] insn_t;
    typedef logic [REG_W-1:0]  reg_t;

    typedef enum logic [2:0] {
        C0_REG   = 3'd0,
        C0_IMM   = 3'd1,
        C0_BR    = 3'd2,
        C0_UPPER = 3'd3,
        C0_PCREL = 3'd4,
        C0_NONE  = 3'd7
    } c0_class_e;

    typedef struct packed {
        logic      legal;
        c0_class_e cls;
        logic      nop;
        logic      writes;
        reg_t      rd;
        reg_t      rs1;
        reg_t      rs2;
        logic [2:0] funct3;
        insn_t     imm;
    } s0_dec_t;

    typedef struct packed {
        logic      legal;
        logic      store;
        logic      nop;
        logic      uses_rs1;
        logic      uses_rs2;
        reg_t      rd;
        reg_t      rs1;
        reg_t      rs2;
        logic [2:0] funct3;
        insn_t     imm;
    } s1_dec_t;

    function automatic logic [6:0] opc_of(insn_t w);
        return w[6:0];
    endfunction

    function automatic reg_t rd_of(insn_t w);
        return w[11:7];
    endfunction

    function automatic reg_t rs1_of(insn_t w);
        return w[19:15];
    endfunction

    function automatic reg_t rs2_of(insn_t w);
        return w[24:20];
    endfunction

    function automatic logic [2:0] f3_of(insn_t w);
        return w[14:12];
    endfunction

    function automatic insn_t imm_i(insn_t w);
        return {{20{w[31]}}, w[31:20]};
    endfunction

    function automatic insn_t imm_s(insn_t w);
        return {{20{w[31]}}, w[31:25], w[11:7]};
    endfunction

    function automatic insn_t imm_b(insn_t w);
        return {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
    endfunction

    function automatic insn_t imm_u(insn_t w);
        return {w[31:12], 12'h000};
    endfunction

endpackage

// File: rtl/pid_alu_slot.sv
module pid_alu_slot
    import pid_pkg::*;
(
    input  insn_t   word,
    output s0_dec_t dec
);
    always_comb begin
        dec        = '0;
        dec.cls    = C0_NONE;
        dec.nop    = (word == FILLER_WORD);
        case (opc_of(word))
            OPC_OP: begin
                dec.legal  = 1'b1;
                dec.cls    = C0_REG;
                dec.writes = 1'b1;
                dec.rd     = rd_of(word);
                dec.rs1    = rs1_of(word);
                dec.rs2    = rs2_of(word);
                dec.funct3 = f3_of(word);
            end
            OPC_OPIMM: begin
                dec.legal  = 1'b1;
                dec.cls    = C0_IMM;
                dec.writes = 1'b1;
                dec.rd     = rd_of(word);
                dec.rs1    = rs1_of(word);
                dec.funct3 = f3_of(word);
                dec.imm    = imm_i(word);
            end
            OPC_BRANCH: begin
                dec.legal  = 1'b1;
                dec.cls    = C0_BR;
                dec.rs1    = rs1_of(word);
                dec.rs2    = rs2_of(word);
                dec.funct3 = f3_of(word);
                dec.imm    = imm_b(word);
            end
            OPC_LUI: begin
                dec.legal  = 1'b1;
                dec.cls    = C0_UPPER;
                dec.writes = 1'b1;
                dec.rd     = rd_of(word);
                dec.imm    = imm_u(word);
            end
            OPC_AUIPC: begin
                dec.legal  = 1'b1;
                dec.cls    = C0_PCREL;
                dec.writes = 1'b1;
                dec.rd     = rd_of(word);
                dec.imm    = imm_u(word);
            end
            default: begin
                dec.legal  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pid_mem_slot.sv
module pid_mem_slot
    import pid_pkg::*;
(
    input  insn_t   word,
    output s1_dec_t dec
);
    always_comb begin
        dec     = '0;
        dec.nop = (word == FILLER_WORD);
        if (dec.nop) begin
            dec.legal = 1'b1;
        end else begin
            case (opc_of(word))
                OPC_LOAD: begin
                    dec.legal    = 1'b1;
                    dec.uses_rs1 = 1'b1;
                    dec.rd       = rd_of(word);
                    dec.rs1      = rs1_of(word);
                    dec.funct3   = f3_of(word);
                    dec.imm      = imm_i(word);
                end
                OPC_STORE: begin
                    dec.legal    = 1'b1;
                    dec.store    = 1'b1;
                    dec.uses_rs1 = 1'b1;
                    dec.uses_rs2 = 1'b1;
                    dec.rs1      = rs1_of(word);
                    dec.rs2      = rs2_of(word);
                    dec.funct3   = f3_of(word);
                    dec.imm      = imm_s(word);
                end
                default: begin
                    dec.legal    = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/pid_dep_check.sv
module pid_dep_check
    import pid_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  s0_dec_t producer,
    input  s1_dec_t consumer,
    output logic    hit
);
    reg_t           src   [NSRC];
    logic           used  [NSRC];
    logic [NSRC-1:0] match;

    assign src[0]  = consumer.rs1;
    assign used[0] = consumer.uses_rs1;
    assign src[1]  = consumer.rs2;
    assign used[1] = consumer.uses_rs2;

    logic live_dest;
    assign live_dest = producer.writes && (producer.rd != '0);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign match[g] = live_dest && used[g] && (src[g] == producer.rd);
    end

    assign hit = |match;
endmodule

// File: rtl/pid_align_check.sv
module pid_align_check #(
    parameter int ADDR_W    = 32,
    parameter int PKT_BYTES = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              misaligned
);
    localparam int LOW_BITS = $clog2(PKT_BYTES);

    assign misaligned = |addr[LOW_BITS-1:0];
endmodule

// File: rtl/pair_issue_decoder.sv
module pair_issue_decoder
    import pid_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid,
    input  logic [ADDR_W-1:0] pkt_addr,
    input  logic [63:0]       pkt_data,
    output logic              s0_valid,
    output logic [2:0]        s0_class,
    output logic              s0_nop,
    output logic [4:0]        s0_rd,
    output logic [4:0]        s0_rs1,
    output logic [4:0]        s0_rs2,
    output logic [2:0]        s0_funct3,
    output logic [31:0]       s0_imm,
    output logic [ADDR_W-1:0] s0_pc,
    output logic              s1_valid,
    output logic              s1_store,
    output logic              s1_nop,
    output logic [4:0]        s1_rd,
    output logic [4:0]        s1_rs1,
    output logic [4:0]        s1_rs2,
    output logic [2:0]        s1_funct3,
    output logic [31:0]       s1_imm,
    output logic [ADDR_W-1:0] s1_pc,
    output logic              err_align,
    output logic              err_slot0,
    output logic              err_slot1,
    output logic              err_dep,
    output logic              pkt_err
);
    localparam logic [ADDR_W-1:0] SLOT_STEP = ADDR_W'(INSN_BYTES);

    insn_t slot_word [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_split
        assign slot_word[g] = pkt_data[g*INSN_W +: INSN_W];
    end

    s0_dec_t d0;
    s1_dec_t d1;
    logic    misaligned;
    logic    dep_hit;

    pid_alu_slot u_alu_slot (
        .word (slot_word[0]),
        .dec  (d0)
    );

    pid_mem_slot u_mem_slot (
        .word (slot_word[1]),
        .dec  (d1)
    );

    pid_dep_check #(.NSRC(2)) u_dep (
        .producer (d0),
        .consumer (d1),
        .hit      (dep_hit)
    );

    pid_align_check #(.ADDR_W(ADDR_W), .PKT_BYTES(PKT_BYTES)) u_align (
        .addr       (pkt_addr),
        .misaligned (misaligned)
    );

    logic any_fault;
    logic accept;

    assign any_fault = misaligned || !d0.legal || !d1.legal || dep_hit;
    assign accept    = pkt_valid && !any_fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            s0_valid  <= 1'b0;
            s1_valid  <= 1'b0;
            err_align <= 1'b0;
            err_slot0 <= 1'b0;
            err_slot1 <= 1'b0;
            err_dep   <= 1'b0;
            pkt_err   <= 1'b0;
            s0_class  <= '0;
            s0_nop    <= 1'b0;
            s0_rd     <= '0;
            s0_rs1    <= '0;
            s0_rs2    <= '0;
            s0_funct3 <= '0;
            s0_imm    <= '0;
            s0_pc     <= '0;
            s1_store  <= 1'b0;
            s1_nop    <= 1'b0;
            s1_rd     <= '0;
            s1_rs1    <= '0;
            s1_rs2    <= '0;
            s1_funct3 <= '0;
            s1_imm    <= '0;
            s1_pc     <= '0;
        end else begin
            s0_valid  <= accept;
            s1_valid  <= accept;
            err_align <= pkt_valid && misaligned;
            err_slot0 <= pkt_valid && !d0.legal;
            err_slot1 <= pkt_valid && !d1.legal;
            err_dep   <= pkt_valid && dep_hit;
            pkt_err   <= pkt_valid && any_fault;
            s0_class  <= d0.cls;
            s0_nop    <= d0.nop;
            s0_rd     <= d0.rd;
            s0_rs1    <= d0.rs1;
            s0_rs2    <= d0.rs2;
            s0_funct3 <= d0.funct3;
            s0_imm    <= d0.imm;
            s0_pc     <= pkt_addr;
            s1_store  <= d1.store;
            s1_nop    <= d1.nop;
            s1_rd     <= d1.rd;
            s1_rs1    <= d1.rs1;
            s1_rs2    <= d1.rs2;
            s1_funct3 <= d1.funct3;
            s1_imm    <= d1.imm;
            s1_pc     <= pkt_addr + SLOT_STEP;
        end
    end
endmodule

// File: rtl/pid_checker.sv
module pid_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              pkt_valid,
    input logic [ADDR_W-1:0] pkt_addr,
    input logic [63:0]       pkt_data,
    input logic              s0_valid,
    input logic              s1_valid,
    input logic              s0_nop,
    input logic              s1_nop,
    input logic [ADDR_W-1:0] s0_pc,
    input logic [ADDR_W-1:0] s1_pc,
    input logic              err_align,
    input logic              err_dep,
    input logic              pkt_err
);
    localparam logic [63:0] FILLER_PAIR = {32'h0000_0013, 32'h0000_0013};

    // R1: first cycle after reset is quiet
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!s0_valid && !s1_valid && !pkt_err));

    // R2: no packet in, nothing out one cycle later
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(pkt_valid) && !$past(rst)) |-> (!s0_valid && !pkt_err));

    // R9: slot valids move together
    p_valid_pair_r9: assert property (@(posedge clk) disable iff (rst)
        s0_valid == s1_valid);

    // R9: an accepted packet carries no error
    p_accept_clean_r9: assert property (@(posedge clk) disable iff (rst)
        s0_valid |-> (!pkt_err && !err_dep && !err_align));

    // R7: misaligned packet is flagged and rejected
    p_misalign_r7: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && (pkt_addr[2:0] != 3'b000)) |=> (err_align && !s0_valid));

    // R10: slot 1 sits one instruction above slot 0
    p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
        s0_valid |-> (s1_pc == s0_pc + ADDR_W'(4)));

    // R5: an aligned all-filler packet is legal
    p_filler_pair_r5: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_data == FILLER_PAIR && pkt_addr[2:0] == 3'b000)
        |=> (s0_valid && s0_nop && s1_nop));
endmodule

bind pair_issue_decoder pid_checker #(.ADDR_W(ADDR_W)) u_pid_checker (
    .clk       (clk),
    .rst       (rst),
    .pkt_valid (pkt_valid),
    .pkt_addr  (pkt_addr),
    .pkt_data  (pkt_data),
    .s0_valid  (s0_valid),
    .s1_valid  (s1_valid),
    .s0_nop    (s0_nop),
    .s1_nop    (s1_nop),
    .s0_pc     (s0_pc),
    .s1_pc     (s1_pc),
    .err_align (err_align),
    .err_dep   (err_dep),
    .pkt_err   (pkt_err)
);

// File: tb/pair_issue_decoder_test.sv
`timescale 1ns/1ps
module pair_issue_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_valid = 1'b0;
    logic [31:0] pkt_addr = '0;
    logic [63:0] pkt_data = '0;

    logic        s0_valid, s0_nop, s1_valid, s1_store, s1_nop;
    logic [2:0]  s0_class, s0_funct3, s1_funct3;
    logic [4:0]  s0_rd, s0_rs1, s0_rs2, s1_rd, s1_rs1, s1_rs2;
    logic [31:0] s0_imm, s1_imm, s0_pc, s1_pc;
    logic        err_align, err_slot0, err_slot1, err_dep, pkt_err;

    always #2 clk = ~clk;

    pair_issue_decoder #(.ADDR_W(32)) uut (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_addr(pkt_addr), .pkt_data(pkt_data),
        .s0_valid(s0_valid), .s0_class(s0_class), .s0_nop(s0_nop), .s0_rd(s0_rd),
        .s0_rs1(s0_rs1), .s0_rs2(s0_rs2), .s0_funct3(s0_funct3), .s0_imm(s0_imm), .s0_pc(s0_pc),
        .s1_valid(s1_valid), .s1_store(s1_store), .s1_nop(s1_nop), .s1_rd(s1_rd),
        .s1_rs1(s1_rs1), .s1_rs2(s1_rs2), .s1_funct3(s1_funct3), .s1_imm(s1_imm), .s1_pc(s1_pc),
        .err_align(err_align), .err_slot0(err_slot0), .err_slot1(err_slot1),
        .err_dep(err_dep), .pkt_err(pkt_err)
    );

    typedef struct {
        string       tag;
        logic        v;
        logic [4:0]  errs;
        logic [2:0]  cls;
        logic        n0, n1, st;
        logic [4:0]  rd0, ra0, rb0, rd1, ra1, rb1;
        logic [2:0]  f0, f1;
        logic [31:0] i0, i1, pc0, pc1;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(logic [4:0] rs2, logic [4:0] rs1, logic [4:0] rd);
        return {7'd0, rs2, rs1, 3'd0, rd, 7'h33};
    endfunction
    function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                          logic [4:0] rd, logic [6:0] opc);
        return {imm, rs1, f3, rd, opc};
    endfunction
    function automatic logic [31:0] enc_s(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                          logic [2:0] f3);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'h23};
    endfunction
    function automatic logic [31:0] enc_b(logic [12:0] imm, logic [4:0] rs2, logic [4:0] rs1);
        return {imm[12], imm[10:5], rs2, rs1, 3'd0, imm[4:1], imm[11], 7'h63};
    endfunction
    function automatic logic [31:0] enc_u(logic [19:0] imm, logic [4:0] rd, logic [6:0] opc);
        return {imm, rd, opc};
    endfunction

    localparam logic [31:0] NOPW = 32'h0000_0013;

    // Expected-value model written from R3..R12
    task automatic send(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                        input logic [31:0] i0, input logic [31:0] i1, input string tag);
        exp_t e;
        logic [6:0] o0, o1;
        logic ok0, ok1, wr, ld, st, dep, al;
        o0 = w0[6:0];
        o1 = w1[6:0];
        e.tag = tag;
        ok0 = 1'b1;
        case (o0)
            7'h33: e.cls = 3'd0;
            7'h13: e.cls = 3'd1;
            7'h63: e.cls = 3'd2;
            7'h37: e.cls = 3'd3;
            7'h17: e.cls = 3'd4;
            default: begin e.cls = 3'd7; ok0 = 1'b0; end
        endcase
        wr  = ok0 && (e.cls != 3'd2);
        e.n0 = (w0 == NOPW);
        e.rd0 = wr ? w0[11:7] : 5'd0;
        e.ra0 = (ok0 && e.cls <= 3'd2) ? w0[19:15] : 5'd0;
        e.rb0 = (e.cls == 3'd0 || e.cls == 3'd2) ? w0[24:20] : 5'd0;
        e.f0  = (ok0 && e.cls <= 3'd2) ? w0[14:12] : 3'd0;
        e.n1 = (w1 == NOPW);
        ld  = !e.n1 && (o1 == 7'h03);
        st  = !e.n1 && (o1 == 7'h23);
        ok1 = e.n1 || ld || st;
        e.st  = st;
        e.rd1 = ld ? w1[11:7] : 5'd0;
        e.ra1 = (ld || st) ? w1[19:15] : 5'd0;
        e.rb1 = st ? w1[24:20] : 5'd0;
        e.f1  = (ld || st) ? w1[14:12] : 3'd0;
        dep = wr && (e.rd0 != 5'd0) &&
              (((ld || st) && e.rd0 == w1[19:15]) || (st && e.rd0 == w1[24:20]));
        al  = (a[2:0] != 3'b000);
        e.errs = {al, !ok0, !ok1, dep, al || !ok0 || !ok1 || dep};
        e.v  = !e.errs[0];
        e.i0 = i0;
        e.i1 = i1;
        e.pc0 = a;
        e.pc1 = a + 32'd4;
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_addr  = a;
        pkt_data  = {w1, w0};
        q.push_back(e);
    endtask

    task automatic idle(input logic [31:0] a, input logic [63:0] junk);
        exp_t e;
        e = '{tag: "R2 idle", v: 1'b0, errs: 5'b0, cls: 3'd0, n0: 1'b0, n1: 1'b0, st: 1'b0,
              rd0: 5'd0, ra0: 5'd0, rb0: 5'd0, rd1: 5'd0, ra1: 5'd0, rb1: 5'd0,
              f0: 3'd0, f1: 3'd0, i0: 32'd0, i1: 32'd0, pc0: 32'd0, pc1: 32'd0};
        @(negedge clk);
        pkt_valid = 1'b0;
        pkt_addr  = a;
        pkt_data  = junk;
        q.push_back(e);
    endtask

    // Monitor: one expectation per clock edge, sampled after the edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(s0_valid == e.v && s1_valid == e.v, {e.tag, " R9"}, "valids",
                  {30'd0, s0_valid, s1_valid}, {30'd0, e.v, e.v});
            check({err_align, err_slot0, err_slot1, err_dep, pkt_err} == e.errs,
                  {e.tag, " R6/R7/R8"}, "errs",
                  {27'd0, err_align, err_slot0, err_slot1, err_dep, pkt_err}, {27'd0, e.errs});
            if (e.v) begin
                check(s0_pc == e.pc0 && s1_pc == e.pc1, {e.tag, " R10"}, "pc1", s1_pc, e.pc1);
                check(s0_class == e.cls && s0_nop == e.n0, {e.tag, " R3"}, "class",
                      {28'd0, s0_nop, s0_class}, {28'd0, e.n0, e.cls});
                check(s1_store == e.st && s1_nop == e.n1, {e.tag, " R4/R5"}, "kind",
                      {30'd0, s1_store, s1_nop}, {30'd0, e.st, e.n1});
                check(s0_imm == e.i0, {e.tag, " R11"}, "imm0", s0_imm, e.i0);
                check(s1_imm == e.i1, {e.tag, " R11"}, "imm1", s1_imm, e.i1);
                check({s0_rd, s0_rs1, s0_rs2, s0_funct3} == {e.rd0, e.ra0, e.rb0, e.f0},
                      {e.tag, " R12"}, "fields0",
                      {14'd0, s0_rd, s0_rs1, s0_rs2, s0_funct3}, {14'd0, e.rd0, e.ra0, e.rb0, e.f0});
                check({s1_rd, s1_rs1, s1_rs2, s1_funct3} == {e.rd1, e.ra1, e.rb1, e.f1},
                      {e.tag, " R12"}, "fields1",
                      {14'd0, s1_rd, s1_rs1, s1_rs2, s1_funct3}, {14'd0, e.rd1, e.ra1, e.rb1, e.f1});
            end
        end
    end

    bit finished = 0;

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        // R1: held in reset
        check({s0_valid, s1_valid, err_align, err_slot0, err_slot1, err_dep, pkt_err} == 7'd0,
              "R1 reset", "outputs", {25'd0, s0_valid, s1_valid, err_align, err_slot0,
              err_slot1, err_dep, pkt_err}, 32'd0);
        rst = 1'b0;

        // R2: junk that would be illegal, with pkt_valid low
        idle(32'h0000_1003, {32'h0000_0033, 32'h0000_0003});

        // R3/R4/R12: register ALU + word load
        send(32'h1000, enc_r(5'd2, 5'd1, 5'd5), enc_i(12'd8, 5'd3, 3'd2, 5'd6, 7'h03),
             32'd0, 32'd8, "R3 add+lw");
        // R11: negative immediates, immediate ALU + store
        send(32'h1008, enc_i(12'hFFB, 5'd4, 3'd0, 5'd9, 7'h13), enc_s(12'hFFC, 5'd10, 5'd11, 3'd2),
             32'hFFFF_FFFB, 32'hFFFF_FFFC, "R11 addi+sw");
        // R8: branch writes nothing even though bits 11:7 equal the load base
        send(32'h1010, enc_b(13'd12, 5'd2, 5'd1), enc_i(12'd0, 5'd12, 3'd2, 5'd8, 7'h03),
             32'd12, 32'd0, "R8 beq+lw nodep");
        send(32'h1018, enc_u(20'h12345, 5'd13, 7'h37), enc_s(12'd16, 5'd14, 5'd15, 3'd2),
             32'h1234_5000, 32'd16, "R11 lui+sw");
        send(32'h1020, enc_u(20'hFFFFF, 5'd16, 7'h17), enc_i(12'hFFF, 5'd18, 3'd0, 5'd17, 7'h03),
             32'hFFFF_F000, 32'hFFFF_FFFF, "R11 auipc+lb");
        // R5: filler words
        send(32'h1028, NOPW, NOPW, 32'd0, 32'd0, "R5 nop+nop");
        send(32'h1030, NOPW, enc_i(12'd4, 5'd6, 3'd2, 5'd5, 7'h03), 32'd0, 32'd4, "R5 nop+lw");
        send(32'h1038, enc_r(5'd7, 5'd6, 5'd5), NOPW, 32'd0, 32'd0, "R5 add+nop");
        idle(32'h0, 64'hFFFF_FFFF_FFFF_FFFF);
        // R6: wrong slot types
        send(32'h2000, enc_i(12'd0, 5'd1, 3'd2, 5'd2, 7'h03), enc_i(12'd0, 5'd3, 3'd2, 5'd4, 7'h03),
             32'd0, 32'd0, "R6 load in slot0");
        send(32'h2008, enc_r(5'd2, 5'd1, 5'd3), enc_r(5'd5, 5'd6, 5'd7), 32'd0, 32'd0, "R6 alu in slot1");
        send(32'h2010, enc_r(5'd2, 5'd1, 5'd3), enc_i(12'd1, 5'd0, 3'd0, 5'd0, 7'h13),
             32'd0, 32'd0, "R6 noncanonical filler slot1");
        send(32'h2018, enc_s(12'd0, 5'd1, 5'd2, 3'd2), enc_r(5'd5, 5'd6, 5'd7), 32'd0, 32'd0, "R6 both slots");
        // R7: misalignment
        send(32'h2004, enc_r(5'd2, 5'd1, 5'd3), enc_i(12'd0, 5'd4, 3'd2, 5'd5, 7'h03), 32'd0, 32'd0, "R7 addr+4");
        send(32'h2003, NOPW, NOPW, 32'd0, 32'd0, "R7 addr+3");
        // R8: dependencies
        send(32'h3000, enc_r(5'd2, 5'd1, 5'd7), enc_i(12'd0, 5'd7, 3'd2, 5'd3, 7'h03), 32'd0, 32'd0, "R8 rs1 dep");
        send(32'h3008, enc_r(5'd2, 5'd1, 5'd7), enc_s(12'd0, 5'd7, 5'd2, 3'd2), 32'd0, 32'd0, "R8 rs2 dep");
        send(32'h3010, enc_r(5'd2, 5'd1, 5'd7), enc_i(12'd7, 5'd2, 3'd2, 5'd3, 7'h03),
             32'd0, 32'd7, "R8 load imm bits no dep");
        send(32'h3018, enc_r(5'd2, 5'd1, 5'd0), enc_i(12'd0, 5'd0, 3'd2, 5'd3, 7'h03), 32'd0, 32'd0, "R8 x0 no dep");
        send(32'h3020, enc_u(20'h00001, 5'd20, 7'h37), enc_i(12'd0, 5'd20, 3'd2, 5'd4, 7'h03),
             32'h0000_1000, 32'd0, "R8 lui dep");
        // R9: misaligned and dependent together
        send(32'h3022, enc_r(5'd2, 5'd1, 5'd9), enc_s(12'd0, 5'd9, 5'd9, 3'd2), 32'd0, 32'd0, "R9 align+dep");
        // R10: top of address space
        send(32'hFFFF_FFF8, enc_r(5'd2, 5'd1, 5'd3), enc_s(12'd0, 5'd4, 5'd5, 3'd0),
             32'd0, 32'd0, "R10 high pc");
        idle(32'h0, 64'h0);
        idle(32'h0, 64'h0);
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule